// File: doc/BRIEF.md
# Dual-Port Shared Register Bank

This block is a bank of four 8-bit registers that two independent ports, A and B, can each write and read. Each port has one data bus that it uses in both directions. It also has a 2-bit register select, an active-low load strobe and an active-low drive strobe. Both ports see the same four registers, so a value written through one port can be read back through the other.

The physical bus is three-state. At this level each port is split into three parts: an input half (`*_bus_i`), an output half (`*_bus_o`) and an output enable (`*_bus_oe`). The pad ring joins them onto one wire. When the enable is low, the port floats, so another agent can place data on the wire.

Writes are sampled on the rising edge of the system clock. Reads are combinational from the strobe and the select, so the stored value appears in the same cycle the drive strobe goes low. These are plain strobe pins, not a stream: there is no valid/ready handshake and no back-pressure. A strobe that is held low acts on every clock edge.

Top module: `dual_port_regset`

## Requirements
- R1: While `rst_n` is low, and after it is released, all four registers read 0x00, the error flag reads 0 and both output enables are 0.
- R2: At each rising clock edge where a port's load strobe is low and its drive strobe is high, the register named by that port's select takes that port's input bus value. If the load strobe is held across several edges, the value at the last edge is kept after release.
- R3: While a port's drive strobe is low, its output enable is 1 and its output bus shows the selected register in the same cycle. While the drive strobe is high, the output enable is 0 and the output bus is 0x00.
- R4: A value written through either port can be read through the other port from the next cycle on.
- R5: Both ports may write different registers at the same edge, and both writes take effect. Both ports may also drive at once, each showing its own selected register.
- R6: When both ports write the same register at the same edge, port A's value is stored.
- R7: When one port drives a register that the other port writes in the same cycle, the driving port shows the old value during that cycle and the new value from the next cycle on.
- R8: A load strobe and a drive strobe both low on one port is treated as a drive only. No write happens, and the error flag goes to 1 at that edge. The error flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; writes and the error flag update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 2 | Port A register select |
| a_load_n | input | 1 | Port A load strobe, active low |
| a_drive_n | input | 1 | Port A drive strobe, active low |
| a_bus_i | input | 8 | Port A bus, incoming half |
| a_bus_o | output | 8 | Port A bus, outgoing half |
| a_bus_oe | output | 1 | Port A bus output enable |
| b_sel | input | 2 | Port B register select |
| b_load_n | input | 1 | Port B load strobe, active low |
| b_drive_n | input | 1 | Port B drive strobe, active low |
| b_bus_i | input | 8 | Port B bus, incoming half |
| b_bus_o | output | 8 | Port B bus, outgoing half |
| b_bus_oe | output | 1 | Port B bus output enable |
| cmd_err | output | 1 | Sticky flag: a port asserted load and drive together |

## Verification
The hardest cases involve both ports touching the same register in one cycle. One case is a write on each port, where port A must win. The other is a write on one port while the other port drives that register, where the reader must see the old value, not the one being written. The vector table sets up these collisions directly: it places both ports on one select within a single row. A later row then reads the register back to show which value landed. The illegal load-plus-drive case is reached by a directed test that holds both strobes low with a fresh data value. The test then confirms that the register kept its earlier contents and that the error flag does not clear without a reset.

// File: rtl/dpreg_pkg.sv
package dpreg_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_DEPTH = 4;
  localparam int unsigned NUM_PORTS = 2;

  // decoded per-port request
  typedef struct packed {
    logic wr;
    logic rd;
    logic bad;
  } port_req_t;
endpackage

// File: rtl/dpreg_port_ctrl.sv
module dpreg_port_ctrl
  import dpreg_pkg::*;
(
  input  logic      load_n,
  input  logic      drive_n,
  output port_req_t req
);
  // load together with drive degrades to drive-only and is flagged
  always_comb begin
    req.rd  = ~drive_n;
    req.wr  = ~load_n & drive_n;
    req.bad = ~load_n & ~drive_n;
  end
endmodule

// File: rtl/dpreg_bank.sv
module dpreg_bank #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SELW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wa_en,
  input  logic [SELW-1:0]             wa_sel,
  input  logic [WIDTH-1:0]            wa_data,
  input  logic                        wb_en,
  input  logic [SELW-1:0]             wb_sel,
  input  logic [WIDTH-1:0]            wb_data,
  output logic [DEPTH-1:0][WIDTH-1:0] q
);
  logic [DEPTH-1:0] hit_a, hit_b;

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    assign hit_a[i] = wa_en && (wa_sel == SELW'(i));
    assign hit_b[i] = wb_en && (wb_sel == SELW'(i));

    // port A ahead of port B on a shared target
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= '0;
      else if (hit_a[i]) q[i] <= wa_data;
      else if (hit_b[i]) q[i] <= wb_data;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_a[i] && !hit_b[i]) |=> $stable(q[i]));
  end

  p_write_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wa_en |=> q[$past(wa_sel)] == $past(wa_data));

  p_b_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !(wa_en && wa_sel == wb_sel)) |=> q[$past(wb_sel)] == $past(wb_data));

  p_a_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en && wa_sel == wb_sel) |=> q[$past(wb_sel)] == $past(wa_data));
endmodule

// File: rtl/dpreg_rdmux.sv
module dpreg_rdmux #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SELW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        en,
  input  logic [SELW-1:0]             sel,
  input  logic [DEPTH-1:0][WIDTH-1:0] q,
  output logic                        oe,
  output logic [WIDTH-1:0]            dout
);
  logic [DEPTH-1:0][WIDTH-1:0] gated;

  // one-hot AND-OR select, zero when the port is not driving
  for (genvar i = 0; i < DEPTH; i++) begin : g_gate
    assign gated[i] = (en && sel == SELW'(i)) ? q[i] : '0;
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < DEPTH; i++) dout |= gated[i];
  end

  assign oe = en;

  always_comb begin
    if (!en) p_quiet_r3: assert (dout == '0);
  end
endmodule

// File: rtl/dual_port_regset.sv
module dual_port_regset
  import dpreg_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned DEPTH = DEF_DEPTH,
  localparam int unsigned SELW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SELW-1:0]  a_sel,
  input  logic             a_load_n,
  input  logic             a_drive_n,
  input  logic [WIDTH-1:0] a_bus_i,
  output logic [WIDTH-1:0] a_bus_o,
  output logic             a_bus_oe,
  input  logic [SELW-1:0]  b_sel,
  input  logic             b_load_n,
  input  logic             b_drive_n,
  input  logic [WIDTH-1:0] b_bus_i,
  output logic [WIDTH-1:0] b_bus_o,
  output logic             b_bus_oe,
  output logic             cmd_err
);
  logic [NUM_PORTS-1:0]            load_n_v, drive_n_v, oe_v;
  logic [NUM_PORTS-1:0][SELW-1:0]  sel_v;
  logic [NUM_PORTS-1:0][WIDTH-1:0] din_v, dout_v;
  port_req_t [NUM_PORTS-1:0]       req;
  logic [DEPTH-1:0][WIDTH-1:0]     q;
  logic                            any_bad;

  assign load_n_v  = {b_load_n, a_load_n};
  assign drive_n_v = {b_drive_n, a_drive_n};
  assign sel_v     = {b_sel, a_sel};
  assign din_v     = {b_bus_i, a_bus_i};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpreg_port_ctrl u_ctrl (
      .load_n  (load_n_v[p]),
      .drive_n (drive_n_v[p]),
      .req     (req[p])
    );
    dpreg_rdmux #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mux (
      .en   (req[p].rd),
      .sel  (sel_v[p]),
      .q    (q),
      .oe   (oe_v[p]),
      .dout (dout_v[p])
    );
  end

  dpreg_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (req[0].wr),
    .wa_sel  (sel_v[0]),
    .wa_data (din_v[0]),
    .wb_en   (req[1].wr),
    .wb_sel  (sel_v[1]),
    .wb_data (din_v[1]),
    .q       (q)
  );

  assign a_bus_o  = dout_v[0];
  assign a_bus_oe = oe_v[0];
  assign b_bus_o  = dout_v[1];
  assign b_bus_oe = oe_v[1];

  assign any_bad = req[0].bad | req[1].bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmd_err <= 1'b0;
    else if (any_bad) cmd_err <= 1'b1;
  end

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_load_n && !a_drive_n) |=> cmd_err);

  p_float_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a_drive_n |-> (!a_bus_oe && a_bus_o == '0));

  p_float_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    b_drive_n |-> (!b_bus_oe && b_bus_o == '0));

  p_drive_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !b_drive_n |-> (b_bus_oe && b_bus_o == q[b_sel]));
endmodule

// File: tb/sim_dual_port_regset.sv
`timescale 1ns/1ps
module sim_dual_port_regset;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] a_sel = '0, b_sel = '0;
  logic       a_load_n = 1'b1, a_drive_n = 1'b1, b_load_n = 1'b1, b_drive_n = 1'b1;
  logic [7:0] a_bus_i = '0, b_bus_i = '0;
  logic [7:0] a_bus_o, b_bus_o;
  logic       a_bus_oe, b_bus_oe, cmd_err;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dual_port_regset u0 (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_load_n(a_load_n), .a_drive_n(a_drive_n),
    .a_bus_i(a_bus_i), .a_bus_o(a_bus_o), .a_bus_oe(a_bus_oe),
    .b_sel(b_sel), .b_load_n(b_load_n), .b_drive_n(b_drive_n),
    .b_bus_i(b_bus_i), .b_bus_o(b_bus_o), .b_bus_oe(b_bus_oe),
    .cmd_err(cmd_err)
  );

  // op: bit0 = load, bit1 = drive
  typedef struct packed {
    logic [1:0] aop; logic [1:0] asel; logic [7:0] ad;
    logic [1:0] bop; logic [1:0] bsel; logic [7:0] bd;
    logic eaoe; logic [7:0] ea; logic eboe; logic [7:0] eb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 2'd0, 8'h5A, 2'd0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00}, // R2 load r0
    '{2'd2, 2'd0, 8'h00, 2'd1, 2'd1, 8'hC3, 1'b1, 8'h5A, 1'b0, 8'h00}, // R3 drive, R2 B load r1
    '{2'd0, 2'd0, 8'h00, 2'd2, 2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h5A}, // R4 A->B
    '{2'd2, 2'd1, 8'h00, 2'd0, 2'd0, 8'h00, 1'b1, 8'hC3, 1'b0, 8'h00}, // R4 B->A
    '{2'd1, 2'd2, 8'h11, 2'd1, 2'd3, 8'hEE, 1'b0, 8'h00, 1'b0, 8'h00}, // R5 dual load
    '{2'd2, 2'd3, 8'h00, 2'd2, 2'd2, 8'h00, 1'b1, 8'hEE, 1'b1, 8'h11}, // R5 dual drive
    '{2'd1, 2'd1, 8'h77, 2'd1, 2'd1, 8'h88, 1'b0, 8'h00, 1'b0, 8'h00}, // R6 collision
    '{2'd0, 2'd0, 8'h00, 2'd2, 2'd1, 8'h00, 1'b0, 8'h00, 1'b1, 8'h77}, // R6 A won
    '{2'd2, 2'd2, 8'h00, 2'd1, 2'd2, 8'h42, 1'b1, 8'h11, 1'b0, 8'h00}, // R7 old value
    '{2'd2, 2'd2, 8'h00, 2'd0, 2'd0, 8'h00, 1'b1, 8'h42, 1'b0, 8'h00}, // R7 new value
    '{2'd1, 2'd3, 8'h99, 2'd2, 2'd3, 8'h00, 1'b0, 8'h00, 1'b1, 8'hEE}, // R7 mirrored
    '{2'd2, 2'd3, 8'h00, 2'd0, 2'd0, 8'h00, 1'b1, 8'h99, 1'b0, 8'h00}  // R7 mirrored after
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_ports(input logic [1:0] aop, input logic [1:0] asel, input logic [7:0] ad,
                             input logic [1:0] bop, input logic [1:0] bsel, input logic [7:0] bd);
    @(negedge clk);
    a_sel = asel; a_load_n = ~aop[0]; a_drive_n = ~aop[1]; a_bus_i = ad;
    b_sel = bsel; b_load_n = ~bop[0]; b_drive_n = ~bop[1]; b_bus_i = bd;
    #1;
  endtask

  task automatic idle();
    drive_ports(2'd0, 2'd0, 8'h00, 2'd0, 2'd0, 8'h00);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 err in reset", {7'd0, cmd_err}, 8'h00);
    check("R1 a_oe in reset", {7'd0, a_bus_oe}, 8'h00);
    check("R1 b_oe in reset", {7'd0, b_bus_oe}, 8'h00);
    rst_n = 1'b1;
    for (int r = 0; r < 4; r++) begin
      drive_ports(2'd2, 2'(r), 8'h00, 2'd0, 2'd0, 8'h00);
      check("R1 reg after reset", a_bus_o, 8'h00);
    end

    for (int v = 0; v < NV; v++) begin
      drive_ports(TBL[v].aop, TBL[v].asel, TBL[v].ad, TBL[v].bop, TBL[v].bsel, TBL[v].bd);
      check($sformatf("R3 row %0d a_oe", v), {7'd0, a_bus_oe}, {7'd0, TBL[v].eaoe});
      check($sformatf("R3 row %0d a_bus", v), a_bus_o, TBL[v].ea);
      check($sformatf("R3 row %0d b_oe", v), {7'd0, b_bus_oe}, {7'd0, TBL[v].eboe});
      check($sformatf("R3 row %0d b_bus", v), b_bus_o, TBL[v].eb);
    end
    check("R8 no error after legal rows", {7'd0, cmd_err}, 8'h00);

    // R2: strobe held across edges, last value kept
    drive_ports(2'd1, 2'd0, 8'h01, 2'd0, 2'd0, 8'h00);
    drive_ports(2'd1, 2'd0, 8'h02, 2'd0, 2'd0, 8'h00);
    drive_ports(2'd1, 2'd0, 8'h03, 2'd0, 2'd0, 8'h00);
    drive_ports(2'd0, 2'd0, 8'hAA, 2'd2, 2'd0, 8'h00);
    check("R2 held strobe keeps last", b_bus_o, 8'h03);

    // R8: load+drive on port A is drive-only, sticky error
    drive_ports(2'd3, 2'd0, 8'hFF, 2'd0, 2'd0, 8'h00);
    check("R8 illegal acts as drive oe", {7'd0, a_bus_oe}, 8'h01);
    check("R8 illegal acts as drive data", a_bus_o, 8'h03);
    drive_ports(2'd2, 2'd0, 8'h00, 2'd0, 2'd0, 8'h00);
    check("R8 no write on illegal", a_bus_o, 8'h03);
    check("R8 error set", {7'd0, cmd_err}, 8'h01);
    repeat (4) idle();
    check("R8 error sticky", {7'd0, cmd_err}, 8'h01);

    // R1: reset clears bank and flag
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 err cleared by reset", {7'd0, cmd_err}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    drive_ports(2'd2, 2'd0, 8'h00, 2'd2, 2'd3, 8'h00);
    check("R1 r0 cleared", a_bus_o, 8'h00);
    check("R1 r3 cleared", b_bus_o, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule